// File: doc/BRIEF.md
# SMBus Management Message Slave

This block is an SMBus slave that an external management controller uses to leave commands and short messages for the host. The controller writes with the SMBus Byte Write format. The first byte after the address picks a register, and the second byte is the value stored there. Register 00h takes commands, and registers 04h and 05h hold two message bytes that the host reads from dedicated output ports. All other register numbers are reserved. The controller can read any register back using the usual write-command, repeated-start, read-address sequence.

A command write produces a one-cycle strobe on the host side. The wake code also raises its own strobe, and the hard-reset code raises a reset strobe. If the hard-reset code arrives while the host reports a deep sleep state, the reset does not run at once. It is held pending until the next wake event. While it is pending, the data byte of every write is refused, including a wake command. Reads still complete. If the bus sits with both lines high for too long in the middle of a transfer, the slave drops the transfer and waits for a new START.

SCL and SDA are oversampled on the system clock through two-flop synchronizers. The slave drives SDA only low, through an output enable.

Top module: `smbus_msg_slave`

## Requirements
- R1: The slave ACKs only an address byte whose upper seven bits equal DEV_ADDR (default 44h, so 88h writes and 89h reads). Any other address is NAKed, and the rest of that transfer is ignored.
- R2: In a write, command byte 04h routes the data byte to msg0 and 05h routes it to msg1. Each of the three bytes is ACKed.
- R3: A new write to a message byte replaces the old value at once, whether or not the host has read it.
- R4: A data byte written to register 00h is stored on cmd_val and pulses cmd_stb for exactly one cycle. If the value equals WAKE_CODE (default 05h), wake_req also pulses.
- R5: Writing RST_CODE (default 03h) to register 00h pulses hard_rst when deep_sleep is 0. When deep_sleep is 1, it sets rst_pending instead and does not pulse hard_rst.
- R6: While rst_pending is 1, the address and command bytes of a write are ACKed, but the data byte is NAKed and discarded. This covers the wake code, so wake_req does not pulse. hard_rst stays low.
- R7: A wake_evt cycle while rst_pending is 1 gives exactly one hard_rst pulse and clears rst_pending.
- R8: A read returns the selected register MSB first: 00h gives the last accepted command value, 04h gives msg0 and 05h gives msg1. Reads complete normally while rst_pending is 1.
- R9: Writes to reserved registers (01h–03h, 06h–FFh) are ACKed and change no output. Reads from reserved registers return 00h.
- R10: If SCL and SDA are both high for IDLE_US microseconds (5000 clocks at defaults) during a transfer, the slave abandons it and ignores bits until the next START. A shorter high phase does not disturb the transfer.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| deep_sleep | input | 1 | Host is in a deep sleep state |
| wake_evt | input | 1 | Host wake event, one cycle |
| sda_oe | output | 1 | Pull SDA low when 1 |
| msg0 | output | 8 | Message byte 0 |
| msg1 | output | 8 | Message byte 1 |
| cmd_val | output | 8 | Last accepted command value |
| cmd_stb | output | 1 | Command accepted strobe |
| wake_req | output | 1 | Wake command strobe |
| hard_rst | output | 1 | Hard reset execute strobe |
| rst_pending | output | 1 | Hard reset waiting for wake |

## Verification
A bit counter that slips or a byte-phase state that goes wrong shows up within one byte time. The ACK or NAK lands on the wrong SCL pulse, or a register other than the addressed one changes. A stuck pending flag shows at the ports on the next write, because the data byte comes back NAKed. A flag that fails to set shows as a hard_rst pulse in the same transfer. The read path brings every stored byte back over the bus, so a wrong register-select decode is seen at the next read of that register.

// File: rtl/smbus_msg_slave.sv
module smbus_msg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h44,
  parameter logic [7:0] RST_CODE  = 8'h03,
  parameter logic [7:0] WAKE_CODE = 8'h05,
  parameter int CLK_HZ  = 100_000_000,
  parameter int IDLE_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       deep_sleep,
  input  logic       wake_evt,
  output logic       sda_oe,
  output logic [7:0] msg0,
  output logic [7:0] msg1,
  output logic [7:0] cmd_val,
  output logic       cmd_stb,
  output logic       wake_req,
  output logic       hard_rst,
  output logic       rst_pending
);
  localparam int IDLE_CYC = (CLK_HZ / 1_000_000) * IDLE_US;
  localparam int TW = $clog2(IDLE_CYC + 1);
  localparam logic [TW-1:0] TOUT = TW'(IDLE_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_t;

  st_t st;
  kind_t kind;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sr, tx, ptr, rd_val;
  logic [3:0] cnt;
  logic rw;
  logic [TW-1:0] tcnt;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire scl_hi   = scl_p[1] & scl_p[2];
  wire start    = scl_hi & sda_p[2] & ~sda_p[1];
  wire stop     = scl_hi & ~sda_p[2] & sda_p[1];
  wire tout     = (tcnt == TOUT);

  always_comb
    case (ptr)
      8'h00:   rd_val = cmd_val;
      8'h04:   rd_val = msg0;
      8'h05:   rd_val = msg1;
      default: rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      tcnt  <= '0;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
      if (st == S_IDLE || !(scl_p[1] && sda_p[1])) tcnt <= '0;
      else if (!tout) tcnt <= tcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; sr <= '0; tx <= '0; ptr <= '0;
      cnt <= '0; rw <= 1'b0; sda_oe <= 1'b0;
      msg0 <= '0; msg1 <= '0; cmd_val <= '0;
      cmd_stb <= 1'b0; wake_req <= 1'b0; hard_rst <= 1'b0; rst_pending <= 1'b0;
    end else begin
      cmd_stb  <= 1'b0;
      wake_req <= 1'b0;
      hard_rst <= 1'b0;
      if (rst_pending && wake_evt) begin
        rst_pending <= 1'b0;
        hard_rst    <= 1'b1;
      end
      if (start) begin
        st <= S_RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop || tout) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else
        case (st)
          S_RX:
            if (scl_rise && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda_p[1]};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              st <= S_ACK; sda_oe <= 1'b1;
              case (kind)
                K_ADDR:
                  if (sr[7:1] != DEV_ADDR) begin st <= S_IDLE; sda_oe <= 1'b0; end
                  else rw <= sr[0];
                K_CMD: ptr <= sr;
                default:
                  if (rst_pending) sda_oe <= 1'b0;
                  else
                    case (ptr)
                      8'h00: begin
                        cmd_val <= sr;
                        cmd_stb <= 1'b1;
                        if (sr == WAKE_CODE) wake_req <= 1'b1;
                        if (sr == RST_CODE) begin
                          if (deep_sleep) rst_pending <= 1'b1;
                          else hard_rst <= 1'b1;
                        end
                      end
                      8'h04: msg0 <= sr;
                      8'h05: msg1 <= sr;
                      default: ;
                    endcase
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              cnt <= '0; sda_oe <= 1'b0;
              if (kind == K_ADDR && rw) begin
                st <= S_TX; tx <= rd_val; sda_oe <= ~rd_val[7];
              end else if (kind == K_ADDR) begin
                st <= S_RX; kind <= K_CMD;
              end else if (kind == K_CMD) begin
                st <= S_RX; kind <= K_DATA;
              end else st <= S_IDLE;
            end
          S_TX:
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                st <= S_TXACK; sda_oe <= 1'b0;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 1'b1;
              end
            end
          S_TXACK: if (scl_rise) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
    end

  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  p_pend_no_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pending && !wake_evt |=> !hard_rst);
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pending |=> $stable(msg0) && $stable(msg1) && !wake_req);
  p_wake_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pending && wake_evt |=> hard_rst && !rst_pending);
  p_sda_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scl_p[1] && $past(scl_p[1]) |-> $stable(sda_oe));
endmodule

// File: tb/smbus_msg_slave_bench.sv
module smbus_msg_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] RSTC = 8'h03, WAKEC = 8'h05;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, deep_sleep = 0, wake_evt = 0;
  logic sda_oe, cmd_stb, wake_req, hard_rst, rst_pending;
  logic [7:0] msg0, msg1, cmd_val;
  wire line = sda_m & ~sda_oe;

  smbus_msg_slave u_smbus_msg_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line),
    .deep_sleep(deep_sleep), .wake_evt(wake_evt), .sda_oe(sda_oe),
    .msg0(msg0), .msg1(msg1), .cmd_val(cmd_val), .cmd_stb(cmd_stb),
    .wake_req(wake_req), .hard_rst(hard_rst), .rst_pending(rst_pending));

  always #5 clk = ~clk;

  int total = 0, fails = 0, n_cmd = 0, n_wake = 0, n_rst = 0, n_viol = 0;
  bit done = 0;
  logic prev_scl = 1, prev_oe = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_stb) n_cmd++;
    if (wake_req) n_wake++;
    if (hard_rst) n_rst++;
    if (scl_m && prev_scl && sda_oe != prev_oe) n_viol++;
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bstart;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic bstop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask
  task automatic wbyte(input logic [7:0] v, input int hold, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; wq(Q); scl_m = 1; wq(i == 7 ? hold : Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q/2); ack = !line; wq(Q/2); scl_m = 0; wq(Q);
  endtask
  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(Q); scl_m = 1; wq(Q/2); v[i] = line; wq(Q/2); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                    input int hold, output logic [2:0] acks);
    bit k0, k1, k2;
    bstart; wbyte(a, Q, k0); wbyte(c, Q, k1); wbyte(d, hold, k2); bstop;
    acks = {k0, k1, k2};
  endtask
  task automatic rd(input logic [7:0] c, output logic [7:0] v, output logic [2:0] acks);
    bit k0, k1, k2;
    bstart; wbyte(8'h88, Q, k0); wbyte(c, Q, k1);
    bstart; wbyte(8'h89, Q, k2); rbyte(v); bstop;
    acks = {k0, k1, k2};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [2:0] a;
    logic [7:0] v, e0, e1, ecmd;
    wq(5); rst_n = 1; wq(5);
    chk("R2 reset msg0", msg0, 0);
    chk("R2 reset msg1", msg1, 0);
    chk("R5 reset pending", rst_pending, 0);
    chk("R11 reset sda_oe", sda_oe, 0);

    wr(8'h8C, 8'h04, 8'h77, Q, a);
    chk("R1 wrong address acks", a, 3'b000);
    chk("R1 wrong address msg0", msg0, 0);

    for (int i = 0; i < 8; i++) begin
      e0 = 8'(i * 37 + 5); e1 = e0 ^ 8'hFF;
      wr(8'h88, 8'h04, e0, Q, a); chk("R2 write acks", a, 3'b111);
      wr(8'h88, 8'h05, e1, Q, a); chk("R2 write acks", a, 3'b111);
      chk("R3 msg0 overwrite", msg0, e0);
      chk("R3 msg1 overwrite", msg1, e1);
      rd(8'h04, v, a); chk("R8 read msg0", v, e0); chk("R8 read acks", a, 3'b111);
      rd(8'h05, v, a); chk("R8 read msg1", v, e1);
    end

    wr(8'h88, 8'h02, 8'h99, Q, a);
    chk("R9 reserved write acks", a, 3'b111);
    chk("R9 reserved msg0", msg0, e0);
    chk("R9 reserved msg1", msg1, e1);
    chk("R9 reserved no strobe", n_cmd, 0);
    foreach (a[k]) ;
    for (int r = 1; r < 10; r++) begin
      if (r == 4 || r == 5) continue;
      rd(8'(r), v, a); chk("R9 reserved read", v, 0);
    end
    rd(8'hFF, v, a); chk("R9 reserved read FF", v, 0);

    ecmd = 8'h42;
    wr(8'h88, 8'h00, ecmd, Q, a);
    chk("R4 cmd acks", a, 3'b111);
    chk("R4 cmd strobe count", n_cmd, 1);
    chk("R4 cmd value", cmd_val, ecmd);
    chk("R4 no wake", n_wake, 0);
    wr(8'h88, 8'h00, WAKEC, Q, a); ecmd = WAKEC;
    chk("R4 wake strobe", n_wake, 1);
    rd(8'h00, v, a); chk("R8 read command reg", v, ecmd);

    wr(8'h88, 8'h00, RSTC, Q, a); ecmd = RSTC;
    chk("R5 awake reset pulse", n_rst, 1);
    chk("R5 awake no pending", rst_pending, 0);
    deep_sleep = 1;
    wr(8'h88, 8'h00, RSTC, Q, a);
    chk("R5 sleep pending", rst_pending, 1);
    chk("R5 sleep no pulse", n_rst, 1);
    chk("R4 strobe count", n_cmd, 4);

    wr(8'h88, 8'h04, 8'h11, Q, a);
    chk("R6 pending write acks", a, 3'b110);
    chk("R6 pending msg0 kept", msg0, e0);
    wr(8'h88, 8'h00, WAKEC, Q, a);
    chk("R6 pending wake nak", a, 3'b110);
    chk("R6 no wake strobe", n_wake, 1);
    chk("R6 no cmd strobe", n_cmd, 4);
    chk("R6 no reset", n_rst, 1);
    rd(8'h04, v, a);
    chk("R8 pending read", v, e0);
    chk("R8 pending read acks", a, 3'b111);
    rd(8'h00, v, a);
    chk("R8 pending read cmd", v, ecmd);

    wake_evt = 1; wq(1); wake_evt = 0; wq(3);
    chk("R7 wake reset pulse", n_rst, 2);
    chk("R7 pending cleared", rst_pending, 0);
    deep_sleep = 0;
    wr(8'h88, 8'h04, 8'h3C, Q, a); e0 = 8'h3C;
    chk("R7 write after wake", msg0, e0);

    wr(8'h88, 8'h04, 8'hA5, 6000, a);
    chk("R10 timeout nak", a, 3'b110);
    chk("R10 timeout msg0 kept", msg0, e0);
    wr(8'h88, 8'h04, 8'hC3, 1000, a);
    chk("R10 short high acks", a, 3'b111);
    chk("R10 short high stored", msg0, 8'hC3);

    chk("R11 sda steady while scl high", n_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule